// File: doc/BRIEF.md
# Load-Store Address Generation Unit

This block forms the two address values that a single-register load or store needs: the byte address sent to memory and the value to be written back into the base register. It takes a base register value, an offset source (a 12-bit unsigned immediate, a second register, or that register passed through a logical shifter) and a decoded indexing mode. An up/down bit selects whether the offset is added to or subtracted from the base. The base is a byte address and the offset is a byte count.

Three indexing modes decide which result uses the adjusted value. Pre-indexed addressing uses the sum for the access and leaves the base alone. Pre-indexed with writeback uses the sum for both. Post-indexed addressing accesses memory at the unmodified base and then updates the base with the sum. Halfword and signed-byte access classes may not take a shifted register offset. For such a request the block raises an illegal flag, suppresses writeback and bypasses the shifter. All results are registered one cycle after a request strobe.

Top module: `ls_agu`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. In cycles without a request, `eff_addr` and `new_base` keep their last values.
- R2: With `idx_mode` 0 (pre-indexed), `eff_addr` is base plus or minus offset, `new_base` equals the base, and `wb_en` is 0.
- R3: With `idx_mode` 1 (pre-indexed with writeback), `eff_addr` and `new_base` both equal base plus or minus offset, and `wb_en` is 1.
- R4: With `idx_mode` 2 (post-indexed), `eff_addr` equals the unmodified base, `new_base` is base plus or minus offset, and `wb_en` is 1.
- R5: `up` = 1 adds the offset and `up` = 0 subtracts it. Arithmetic wraps modulo 2^32 with no flag.
- R6: `off_src` 0 selects `imm12` zero-extended. Code 1 selects `off_reg` unchanged. Code 2 selects `off_reg` through the shifter. Code 3 acts as code 1.
- R7: `sh_kind` 0 shifts left logically by `sh_amt` and `sh_kind` 1 shifts right logically. A shift amount of 0 leaves the register unchanged for both kinds.
- R8: `acc_class` codes are 0 word, 1 unsigned byte, 2 halfword and 3 signed byte. With `off_src` 2 and class 2 or 3, `illegal` is 1 and `wb_en` is 0. In that case `new_base` equals the base and the offset is the unshifted `off_reg`.
- R9: `idx_mode` 3 is reserved. It raises `illegal`, forces `wb_en` to 0, leaves `new_base` equal to the base, and places base plus or minus offset on `eff_addr`.
- R10: While `rst_n` is low, and in the first cycle after it, `rsp_valid`, `wb_en`, `illegal`, `eff_addr` and `new_base` are all 0.
- R11: `wb_en` and `illegal` are only ever high together with `rsp_valid`, and never both high at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; the inputs below are sampled when high |
| base_val | input | 32 | Base register value (byte address) |
| imm12 | input | 12 | Unsigned immediate offset |
| off_reg | input | 32 | Offset register value |
| off_src | input | 2 | Offset source select |
| sh_kind | input | 1 | Shift kind: 0 left, 1 right |
| sh_amt | input | 5 | Shift amount |
| up | input | 1 | 1 add offset, 0 subtract |
| idx_mode | input | 2 | Indexing mode |
| acc_class | input | 2 | Access class |
| rsp_valid | output | 1 | Results valid |
| eff_addr | output | 32 | Effective access address |
| new_base | output | 32 | Value for the base register |
| wb_en | output | 1 | Base writeback enable |
| illegal | output | 1 | Illegal combination of offset form, class or mode |

## Verification
The assertions assume that every input is known and stable at the clock edge where `req_valid` is sampled. They also assume that reset is held long enough for `req_valid` to be low before the first request. The bench drives all inputs on the falling edge, so each request is settled well before the sampling edge. It keeps `req_valid` low throughout reset, including when reset is applied again in the middle of a run.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

  typedef enum logic [1:0] {
    IDX_PRE    = 2'd0,
    IDX_PRE_WB = 2'd1,
    IDX_POST   = 2'd2,
    IDX_RSVD   = 2'd3
  } idx_mode_e;

  typedef enum logic [1:0] {
    SRC_IMM   = 2'd0,
    SRC_REG   = 2'd1,
    SRC_SHREG = 2'd2,
    SRC_REG_B = 2'd3
  } off_src_e;

  typedef enum logic {
    SH_LSL = 1'b0,
    SH_LSR = 1'b1
  } sh_kind_e;

  typedef enum logic [1:0] {
    CLS_WORD  = 2'd0,
    CLS_UBYTE = 2'd1,
    CLS_HALF  = 2'd2,
    CLS_SBYTE = 2'd3
  } acc_class_e;

endpackage

// File: rtl/lsag_offset_sel.sv
module lsag_offset_sel
  import lsag_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 12,
  parameter int SHW   = 5
) (
  input  logic [1:0]       src,
  input  logic             sh_kind,
  input  logic [SHW-1:0]   sh_amt,
  input  logic [IMM_W-1:0] imm,
  input  logic [W-1:0]     rval,
  input  logic             block_shift,
  output logic [W-1:0]     offset,
  output logic             shift_used
);

  // Logical shift; an amount of zero means no shift for either direction (R7)
  function automatic logic [W-1:0] shift_op(input logic [W-1:0] v,
                                            input logic k,
                                            input logic [SHW-1:0] a);
    if (a == '0) return v;
    return (k == SH_LSR) ? (v >> a) : (v << a);
  endfunction

  logic [W-1:0] imm_ext;
  logic [W-1:0] shifted_val;

  generate
    if (IMM_W < W) begin : g_imm_pad
      assign imm_ext = {{(W-IMM_W){1'b0}}, imm};
    end else begin : g_imm_trunc
      assign imm_ext = imm[W-1:0];
    end
  endgenerate

  assign shifted_val = shift_op(rval, sh_kind, sh_amt);

  always_comb begin
    shift_used = 1'b0;
    case (off_src_e'(src))
      SRC_IMM:   offset = imm_ext;
      SRC_SHREG: begin
        shift_used = !block_shift;
        offset     = block_shift ? rval : shifted_val;
      end
      default:   offset = rval;
    endcase
  end

endmodule

// File: rtl/lsag_index_ctl.sv
module lsag_index_ctl
  import lsag_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] src,
  input  logic [1:0] cls,
  output logic       class_bad,
  output logic       mode_bad,
  output logic       addr_from_sum,
  output logic       base_takes_sum
);

  logic narrow_signed;

  // Halfword and signed-byte classes may not use a shifted offset (R8)
  assign narrow_signed = (acc_class_e'(cls) == CLS_HALF) ||
                         (acc_class_e'(cls) == CLS_SBYTE);
  assign class_bad     = narrow_signed && (off_src_e'(src) == SRC_SHREG);
  assign mode_bad      = (idx_mode_e'(mode) == IDX_RSVD);

  always_comb begin
    addr_from_sum  = 1'b1;
    base_takes_sum = 1'b0;
    case (idx_mode_e'(mode))
      IDX_PRE:    base_takes_sum = 1'b0;
      IDX_PRE_WB: base_takes_sum = 1'b1;
      IDX_POST: begin
        addr_from_sum  = 1'b0;
        base_takes_sum = 1'b1;
      end
      default:    base_takes_sum = 1'b0;
    endcase
    if (class_bad) base_takes_sum = 1'b0;
  end

endmodule

// File: rtl/lsag_addsub.sv
module lsag_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         up,
  output logic [W-1:0] sum
);

  // Wraps modulo 2^W, no carry out (R5)
  function automatic logic [W-1:0] addsub(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic u);
    return u ? (x + y) : (x - y);
  endfunction

  assign sum = addsub(a, b, up);

endmodule

// File: rtl/ls_agu.sv
module ls_agu
  import lsag_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 12,
  parameter int SHW   = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [W-1:0]     base_val,
  input  logic [IMM_W-1:0] imm12,
  input  logic [W-1:0]     off_reg,
  input  logic [1:0]       off_src,
  input  logic             sh_kind,
  input  logic [SHW-1:0]   sh_amt,
  input  logic             up,
  input  logic [1:0]       idx_mode,
  input  logic [1:0]       acc_class,
  output logic             rsp_valid,
  output logic [W-1:0]     eff_addr,
  output logic [W-1:0]     new_base,
  output logic             wb_en,
  output logic             illegal
);

  logic         class_bad;
  logic         mode_bad;
  logic         addr_from_sum;
  logic         base_takes_sum;
  logic         shift_used;
  logic [W-1:0] offset;
  logic [W-1:0] adj_sum;
  logic [W-1:0] addr_next;
  logic [W-1:0] base_next;
  logic         illegal_next;

  lsag_index_ctl u_ctl (
    .mode           (idx_mode),
    .src            (off_src),
    .cls            (acc_class),
    .class_bad      (class_bad),
    .mode_bad       (mode_bad),
    .addr_from_sum  (addr_from_sum),
    .base_takes_sum (base_takes_sum)
  );

  lsag_offset_sel #(.W(W), .IMM_W(IMM_W), .SHW(SHW)) u_off (
    .src         (off_src),
    .sh_kind     (sh_kind),
    .sh_amt      (sh_amt),
    .imm         (imm12),
    .rval        (off_reg),
    .block_shift (class_bad),
    .offset      (offset),
    .shift_used  (shift_used)
  );

  lsag_addsub #(.W(W)) u_add (
    .a   (base_val),
    .b   (offset),
    .up  (up),
    .sum (adj_sum)
  );

  assign addr_next    = addr_from_sum  ? adj_sum : base_val;
  assign base_next    = base_takes_sum ? adj_sum : base_val;
  assign illegal_next = class_bad || mode_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      wb_en     <= 1'b0;
      illegal   <= 1'b0;
      eff_addr  <= '0;
      new_base  <= '0;
    end else begin
      rsp_valid <= req_valid;
      wb_en     <= req_valid && base_takes_sum;
      illegal   <= req_valid && illegal_next;
      if (req_valid) begin
        eff_addr <= addr_next;
        new_base <= base_next;
      end
    end
  end

endmodule

// File: rtl/lsag_checker.sv
module lsag_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic [W-1:0] base_val,
  input logic [1:0]   off_src,
  input logic [1:0]   idx_mode,
  input logic [1:0]   acc_class,
  input logic         shift_used,
  input logic         rsp_valid,
  input logic [W-1:0] eff_addr,
  input logic [W-1:0] new_base,
  input logic         wb_en,
  input logic         illegal
);

  logic narrow_shreg;
  assign narrow_shreg = (off_src == 2'd2) && acc_class[1];

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r1_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(eff_addr) && $stable(new_base)));

  a_r2_pre_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_mode == 2'd0) |=> (!wb_en && new_base == $past(base_val)));

  a_r3_prewb_same_value: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_mode == 2'd1 && !narrow_shreg) |=> (wb_en && eff_addr == new_base));

  a_r4_post_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_mode == 2'd2) |=> (eff_addr == $past(base_val)));

  a_r8_no_shift_on_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_shreg |-> !shift_used);

  a_r8_narrow_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && narrow_shreg) |=> (illegal && !wb_en && new_base == $past(base_val)));

  a_r9_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_mode == 2'd3) |=> (illegal && !wb_en));

  a_r11_flags_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en || illegal) |-> rsp_valid);

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_en && illegal));

endmodule

bind ls_agu lsag_checker #(.W(W)) u_lsag_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .base_val   (base_val),
  .off_src    (off_src),
  .idx_mode   (idx_mode),
  .acc_class  (acc_class),
  .shift_used (shift_used),
  .rsp_valid  (rsp_valid),
  .eff_addr   (eff_addr),
  .new_base   (new_base),
  .wb_en      (wb_en),
  .illegal    (illegal)
);

// File: tb/test_ls_agu.sv
module test_ls_agu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] base_val = '0;
  logic [11:0] imm12 = '0;
  logic [31:0] off_reg = '0;
  logic [1:0]  off_src = '0;
  logic        sh_kind = 1'b0;
  logic [4:0]  sh_amt = '0;
  logic        up = 1'b0;
  logic [1:0]  idx_mode = '0;
  logic [1:0]  acc_class = '0;
  logic        rsp_valid;
  logic [31:0] eff_addr;
  logic [31:0] new_base;
  logic        wb_en;
  logic        illegal;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  ls_agu i_ls_agu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
    .imm12(imm12), .off_reg(off_reg), .off_src(off_src), .sh_kind(sh_kind),
    .sh_amt(sh_amt), .up(up), .idx_mode(idx_mode), .acc_class(acc_class),
    .rsp_valid(rsp_valid), .eff_addr(eff_addr), .new_base(new_base),
    .wb_en(wb_en), .illegal(illegal)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  mode;
    logic [1:0]  src;
    logic        kind;
    logic [4:0]  amt;
    logic        upd;
    logic [1:0]  cls;
    logic [31:0] base;
    logic [11:0] imm;
    logic [31:0] rg;
    logic [31:0] e_eff;
    logic [31:0] e_nb;
    logic        e_wb;
    logic        e_ill;
  } vec_t;

  localparam int NV = 14;
  // req column names the main requirement each vector targets
  localparam vec_t VEC [NV] = '{
    '{8'd2,  2'd0, 2'd0, 1'b0, 5'd0,  1'b1, 2'd0, 32'h0000_1000, 12'h004, 32'h0,         32'h0000_1004, 32'h0000_1000, 1'b0, 1'b0}, // R2
    '{8'd3,  2'd1, 2'd1, 1'b0, 5'd0,  1'b1, 2'd0, 32'h0000_2000, 12'h000, 32'h10,        32'h0000_2010, 32'h0000_2010, 1'b1, 1'b0}, // R3 R6
    '{8'd4,  2'd2, 2'd0, 1'b0, 5'd0,  1'b0, 2'd0, 32'h0000_3000, 12'h008, 32'h0,         32'h0000_3000, 32'h0000_2FF8, 1'b1, 1'b0}, // R4 R5
    '{8'd7,  2'd0, 2'd2, 1'b0, 5'd2,  1'b1, 2'd0, 32'h0000_0100, 12'h000, 32'h3,         32'h0000_010C, 32'h0000_0100, 1'b0, 1'b0}, // R7 LSL
    '{8'd7,  2'd1, 2'd2, 1'b1, 5'd4,  1'b0, 2'd1, 32'h0000_1000, 12'h000, 32'h200,       32'h0000_0FE0, 32'h0000_0FE0, 1'b1, 1'b0}, // R7 LSR
    '{8'd7,  2'd0, 2'd2, 1'b1, 5'd0,  1'b1, 2'd0, 32'h0000_0000, 12'h000, 32'h55,        32'h0000_0055, 32'h0000_0000, 1'b0, 1'b0}, // R7 zero amount
    '{8'd5,  2'd2, 2'd0, 1'b0, 5'd0,  1'b1, 2'd0, 32'hFFFF_FFFC, 12'h008, 32'h0,         32'hFFFF_FFFC, 32'h0000_0004, 1'b1, 1'b0}, // R5 wrap up
    '{8'd8,  2'd1, 2'd2, 1'b0, 5'd1,  1'b1, 2'd2, 32'h0000_0040, 12'h000, 32'h10,        32'h0000_0050, 32'h0000_0040, 1'b0, 1'b1}, // R8 halfword
    '{8'd8,  2'd2, 2'd2, 1'b1, 5'd2,  1'b1, 2'd3, 32'h0000_0080, 12'h000, 32'h8,         32'h0000_0080, 32'h0000_0080, 1'b0, 1'b1}, // R8 signed byte
    '{8'd9,  2'd3, 2'd0, 1'b0, 5'd0,  1'b1, 2'd0, 32'h0000_0500, 12'h020, 32'h0,         32'h0000_0520, 32'h0000_0500, 1'b0, 1'b1}, // R9
    '{8'd5,  2'd1, 2'd0, 1'b0, 5'd0,  1'b0, 2'd0, 32'h0000_0010, 12'h020, 32'h0,         32'hFFFF_FFF0, 32'hFFFF_FFF0, 1'b1, 1'b0}, // R5 wrap down
    '{8'd6,  2'd0, 2'd0, 1'b0, 5'd0,  1'b1, 2'd0, 32'h0000_0000, 12'hFFF, 32'hFFFF_FFFF, 32'h0000_0FFF, 32'h0000_0000, 1'b0, 1'b0}, // R6 imm max
    '{8'd7,  2'd0, 2'd2, 1'b0, 5'd31, 1'b1, 2'd0, 32'h0000_0000, 12'h000, 32'h1,         32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0}, // R7 LSL 31
    '{8'd6,  2'd1, 2'd3, 1'b0, 5'd3,  1'b1, 2'd2, 32'h0000_0100, 12'h000, 32'h4,         32'h0000_0104, 32'h0000_0104, 1'b1, 1'b0}  // R6 code 3 unshifted
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    idx_mode  = v.mode;
    off_src   = v.src;
    sh_kind   = v.kind;
    sh_amt    = v.amt;
    up        = v.upd;
    acc_class = v.cls;
    base_val  = v.base;
    imm12     = v.imm;
    off_reg   = v.rg;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R10", "eff_addr", eff_addr, 32'd0);
    check("R10", "new_base", new_base, 32'd0);
    check("R10", "wb_en|illegal", {30'b0, wb_en, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "rsp_valid after release", {31'b0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      drive(VEC[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(tag, "rsp_valid (R1)", {31'b0, rsp_valid}, 32'd1);
      check(tag, "eff_addr", eff_addr, VEC[i].e_eff);
      check(tag, "new_base", new_base, VEC[i].e_nb);
      check(tag, "wb_en", {31'b0, wb_en}, {31'b0, VEC[i].e_wb});
      check(tag, "illegal (R11)", {31'b0, illegal}, {31'b0, VEC[i].e_ill});
    end

    // R1: inputs change without a request; results hold, no valid
    base_val = 32'hDEAD_BEEF;
    off_reg  = 32'h1234_5678;
    idx_mode = 2'd1;
    repeat (2) @(negedge clk);
    check("R1", "rsp_valid idle", {31'b0, rsp_valid}, 32'd0);
    check("R1", "eff_addr held", eff_addr, 32'h0000_0104);
    check("R1", "new_base held", new_base, 32'h0000_0104);
    check("R11", "wb_en idle", {31'b0, wb_en}, 32'd0);

    // R1: back-to-back requests
    drive(VEC[1]);
    req_valid = 1'b1;
    @(negedge clk);
    check("R1", "b2b first eff", eff_addr, 32'h0000_2010);
    drive(VEC[2]);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", "b2b second valid", {31'b0, rsp_valid}, 32'd1);
    check("R4", "b2b second nb", new_base, 32'h0000_2FF8);

    // R10: reset applied after activity clears results
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "re-reset eff_addr", eff_addr, 32'd0);
    check("R10", "re-reset new_base", new_base, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule